// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a word-wide memory port. Every line holds a valid flag, a tag and a block of four words. Each request is checked against the line its index selects. A read that hits returns the chosen word in the same cycle without stalling. A read miss stalls the processor, fetches the whole block from memory one word at a time, installs it, and then returns the requested word.

Stores follow a write-through policy: every store is sent to memory as a single-word write, and the processor stays stalled until memory accepts it. A store that hits also updates the cached word. A store that misses first refills the complete block from memory and then merges the stored word into it, so the line always matches memory.

The processor keeps its request, address, direction and data stable for as long as the stall output is high. The memory port uses a request/ready handshake. A transfer completes in a cycle where both are high, and read data is taken in that same cycle.

Top module: `dm_wt_cache`

## Requirements
- R1: Reset clears every valid flag, so the first access to any line misses; after reset with no request the stall output and the memory request are both low.
- R2: The byte address splits into a tag in bits [31:16], a line index in bits [15:4], a word select in bits [3:2], and bits [1:0], which are ignored.
- R3: A request hits only when the indexed line is valid and its stored tag equals the address tag; a read hit raises no stall and makes no memory request.
- R4: On a read, the word select picks word 0 to 3 of the line, word 0 being the lowest address, and that word appears on the read data output.
- R5: A miss makes exactly four memory reads, in ascending order from the block-aligned address and four bytes apart, one handshake each; the line then takes the new data, tag and valid flag, and the requested word is returned.
- R6: Every store makes exactly one memory write, with the word-aligned store address and the store data.
- R7: A store hit updates the cached word, so a later read of that address hits and returns the stored value.
- R8: A store miss first refills the whole block from memory, then merges the stored word; the other three words of the line keep their memory values and read as hits.
- R9: From reset, reads of 0x14, 0x1C, 0x34, 0x20014 and 0x14 give miss, hit (word 3), miss, miss (tag 2 replaces tag 0 in line 1), and miss.
- R10: Stall stays high from the cycle a miss or store is seen until the word is returned or the write is accepted. The memory request, address, direction and data stay stable while ready is low. With a memory that is always ready, a read miss stalls 5 cycles, a store hit 1 and a store miss 6.
- R11: With no processor request the block makes no memory request and does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a read is not stalled |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken on the handshake cycle |
| mem_ready | input | 1 | Memory accepts or completes the transfer |

## Verification
The properties assume a processor that holds its request, direction, address and data unchanged while the stall output is high, and that drops its request only after the cycle in which the stall is low. The bench applies each new access only after that completion edge and releases the request only between accesses. For memory, the properties assume only that ready may arrive in any cycle. The bench plays the table twice: once against a memory that is always ready, and once against a memory that withholds ready for two out of every three cycles. This exercises the hold rule without violating the processor-side assumption.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/dmwt_addr_split.sv
module dmwt_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int TAG_W   = 16,
   parameter int INDEX_W = 12,
   parameter int WOFF_W  = 2,
   parameter int BOFF_W  = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [TAG_W-1:0]   tag,
   output logic [INDEX_W-1:0] index,
   output logic [WOFF_W-1:0]  woff,
   output logic [BOFF_W-1:0]  boff
);
   localparam int IDX_LO = BOFF_W + WOFF_W;
   localparam int TAG_LO = IDX_LO + INDEX_W;

   assign boff  = addr[BOFF_W-1:0];
   assign woff  = addr[BOFF_W +: WOFF_W];
   assign index = addr[IDX_LO +: INDEX_W];
   assign tag   = addr[TAG_LO +: TAG_W];
endmodule

// File: rtl/dmwt_line_store.sv
module dmwt_line_store #(
   parameter int TAG_W      = 16,
   parameter int INDEX_W    = 12,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [INDEX_W-1:0]            rd_index,
   output logic                          rd_valid,
   output logic [TAG_W-1:0]              rd_tag,
   output logic [WORD_W*LINE_WORDS-1:0]  rd_line,
   input  logic                          wr_en,
   input  logic [INDEX_W-1:0]            wr_index,
   input  logic [$clog2(LINE_WORDS)-1:0] wr_woff,
   input  logic [WORD_W-1:0]             wr_word,
   input  logic                          tag_en,
   input  logic [TAG_W-1:0]              tag_val
);
   localparam int LINES  = 1 << INDEX_W;
   localparam int LINE_W = WORD_W * LINE_WORDS;

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (tag_en) begin
         valid_q[wr_index] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (tag_en) begin
         tag_q[wr_index] <= tag_val;
      end
      if (wr_en) begin
         data_q[wr_index][wr_woff*WORD_W +: WORD_W] <= wr_word;
      end
   end

   assign rd_valid = valid_q[rd_index];
   assign rd_tag   = tag_q[rd_index];
   assign rd_line  = data_q[rd_index];
endmodule

// File: rtl/dmwt_ctrl.sv
module dmwt_ctrl
   import dmwt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int WOFF_W = 2,
   parameter int BOFF_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_req,
   input  logic                       cpu_we,
   input  logic [ADDR_W-BOFF_W-1:0]   cpu_waddr,
   input  logic [WORD_W-1:0]          cpu_wdata,
   input  logic                       hit,
   input  logic                       mem_ready,
   output logic                       cpu_stall,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [WORD_W-1:0]          mem_wdata,
   output logic                       fill_wr,
   output logic                       fill_last,
   output logic [WOFF_W-1:0]          fill_woff,
   output logic [ADDR_W-WOFF_W-BOFF_W-1:0] fill_blk,
   output logic                       store_wr
);
   localparam int WADDR_W = ADDR_W - BOFF_W;
   localparam int BLK_W   = WADDR_W - WOFF_W;

   ctl_state_e        state_q, state_d;
   logic [WOFF_W-1:0] cnt_q;
   logic [BLK_W-1:0]  blk_q;
   logic [WADDR_W-1:0] wt_addr_q;
   logic [WORD_W-1:0] wt_data_q;

   always_comb begin
      state_d   = state_q;
      cpu_stall = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      fill_wr   = 1'b0;
      fill_last = 1'b0;
      store_wr  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (!hit) begin
                  cpu_stall = 1'b1;
                  state_d   = ST_FILL;
               end else if (cpu_we) begin
                  cpu_stall = 1'b1;
                  store_wr  = 1'b1;
                  state_d   = ST_WRITE;
               end
            end
         end
         ST_FILL: begin
            cpu_stall = 1'b1;
            mem_req   = 1'b1;
            if (mem_ready) begin
               fill_wr = 1'b1;
               if (cnt_q == {WOFF_W{1'b1}}) begin
                  fill_last = 1'b1;
                  state_d   = ST_IDLE;
               end
            end
         end
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            cpu_stall = !mem_ready;
            if (mem_ready) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         blk_q     <= '0;
         wt_addr_q <= '0;
         wt_data_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req && !hit) begin
            blk_q <= cpu_waddr[WADDR_W-1 -: BLK_W];
            cnt_q <= '0;
         end
         if (store_wr) begin
            wt_addr_q <= cpu_waddr;
            wt_data_q <= cpu_wdata;
         end
         if (fill_wr) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign mem_addr  = (state_q == ST_WRITE) ? {wt_addr_q, {BOFF_W{1'b0}}}
                                            : {blk_q, cnt_q, {BOFF_W{1'b0}}};
   assign mem_wdata = wt_data_q;
   assign fill_woff = cnt_q;
   assign fill_blk  = blk_q;
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int INDEX_W    = 12,
   parameter int LINE_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   localparam int BOFF_W = $clog2(WORD_W / 8);
   localparam int WOFF_W = $clog2(LINE_WORDS);
   localparam int TAG_W  = ADDR_W - INDEX_W - WOFF_W - BOFF_W;
   localparam int BLK_W  = ADDR_W - WOFF_W - BOFF_W;
   localparam int LINE_W = WORD_W * LINE_WORDS;

   if (WORD_W < 16 || (WORD_W % 8) != 0 || (1 << BOFF_W) != (WORD_W / 8)) begin : g_bad_word
      $error("WORD_W must be a power-of-two byte count of at least 16 bits");
   end
   if (LINE_WORDS < 2 || (1 << WOFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (INDEX_W < 1 || TAG_W < 1) begin : g_bad_split
      $error("INDEX_W leaves no room for a tag");
   end

   logic [TAG_W-1:0]   req_tag;
   logic [INDEX_W-1:0] req_index;
   logic [WOFF_W-1:0]  req_woff;
   logic [BOFF_W-1:0]  byte_sel_unused;

   dmwt_addr_split #(
      .ADDR_W (ADDR_W), .TAG_W (TAG_W), .INDEX_W (INDEX_W),
      .WOFF_W (WOFF_W), .BOFF_W (BOFF_W)
   ) u_split (
      .addr  (cpu_addr),
      .tag   (req_tag),
      .index (req_index),
      .woff  (req_woff),
      .boff  (byte_sel_unused)
   );

   logic               line_valid;
   logic [TAG_W-1:0]   line_tag;
   logic [LINE_W-1:0]  line_data;
   logic               hit;

   logic               fill_wr, fill_last, store_wr;
   logic [WOFF_W-1:0]  fill_woff;
   logic [BLK_W-1:0]   fill_blk;

   logic               st_wr_en;
   logic [INDEX_W-1:0] st_index;
   logic [WOFF_W-1:0]  st_woff;
   logic [WORD_W-1:0]  st_word;

   assign hit = line_valid && (line_tag == req_tag);

   assign st_wr_en = fill_wr | store_wr;
   assign st_index = fill_wr ? fill_blk[INDEX_W-1:0] : req_index;
   assign st_woff  = fill_wr ? fill_woff : req_woff;
   assign st_word  = fill_wr ? mem_rdata : cpu_wdata;

   dmwt_line_store #(
      .TAG_W (TAG_W), .INDEX_W (INDEX_W),
      .WORD_W (WORD_W), .LINE_WORDS (LINE_WORDS)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_index (req_index),
      .rd_valid (line_valid),
      .rd_tag   (line_tag),
      .rd_line  (line_data),
      .wr_en    (st_wr_en),
      .wr_index (st_index),
      .wr_woff  (st_woff),
      .wr_word  (st_word),
      .tag_en   (fill_last),
      .tag_val  (fill_blk[BLK_W-1:INDEX_W])
   );

   dmwt_ctrl #(
      .ADDR_W (ADDR_W), .WORD_W (WORD_W),
      .WOFF_W (WOFF_W), .BOFF_W (BOFF_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_waddr (cpu_addr[ADDR_W-1:BOFF_W]),
      .cpu_wdata (cpu_wdata),
      .hit       (hit),
      .mem_ready (mem_ready),
      .cpu_stall (cpu_stall),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .fill_wr   (fill_wr),
      .fill_last (fill_last),
      .fill_woff (fill_woff),
      .fill_blk  (fill_blk),
      .store_wr  (store_wr)
   );

   logic [WORD_W-1:0] line_words [LINE_WORDS];
   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word_sel
      assign line_words[w] = line_data[w*WORD_W +: WORD_W];
   end
   assign cpu_rdata = line_words[req_woff];
endmodule

// File: rtl/dmwt_checker.sv
module dmwt_checker #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata
);
   localparam int BOFF_W = $clog2(WORD_W / 8);
   localparam int WOFF_W = $clog2(LINE_WORDS);

   a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

   a_r5_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && !mem_we && (mem_addr[BOFF_W +: WOFF_W] != {WOFF_W{1'b1}}))
      |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(WORD_W / 8))));

   a_r5_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> cpu_stall);

   a_r3_read_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

   a_r6_store_ends_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_stall) |-> (mem_req && mem_we && mem_ready));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> (!mem_req && !cpu_stall));
endmodule

bind dm_wt_cache dmwt_checker #(
   .ADDR_W (ADDR_W), .WORD_W (WORD_W), .LINE_WORDS (LINE_WORDS)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/tb_dm_wt_cache.sv
`timescale 1ns/1ps
module tb_dm_wt_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b1;

   always #2 clk = ~clk;

   dm_wt_cache dut (
      .clk (clk), .rst_n (rst_n),
      .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
      .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .cpu_stall (cpu_stall),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ready (mem_ready)
   );

   int checks = 0;
   int fails = 0;

   // Memory model: fixed pattern per word, overridden by observed writes.
   logic [31:0] ovl [logic [31:0]];
   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h3C5A, ~a[31:16]};
   endfunction
   function automatic logic [31:0] model_rd(input logic [31:0] a);
      logic [31:0] al;
      al = {a[31:2], 2'b00};
      if (ovl.exists(al)) return ovl[al];
      return pat(al);
   endfunction

   bit wait_mode = 1'b0;
   int beat_ctr = 0;
   always @(negedge clk) begin
      beat_ctr++;
      mem_ready <= wait_mode ? ((beat_ctr % 3) == 0) : 1'b1;
      mem_rdata <= model_rd(mem_addr);
   end

   int rd_seen = 0, wr_seen = 0, order_err = 0, hold_err = 0, idle_xfers = 0;
   logic [31:0] cur_blk = '0, last_waddr = '0, last_wdata = '0;
   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ready) begin
         idle_xfers++;
         if (mem_we) begin
            ovl[mem_addr] = mem_wdata;
            wr_seen++;
            last_waddr = mem_addr;
            last_wdata = mem_wdata;
         end else begin
            if (mem_addr != cur_blk + 32'(rd_seen * 4)) order_err++;
            rd_seen++;
         end
      end
   end

   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;
   always @(posedge clk) begin
      if (rst_n && prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err++;
      prev_wait = rst_n && mem_req && !mem_ready;
      prev_addr = mem_addr;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, input logic miss);
      int stalls = 0;
      bit done = 0;
      logic [31:0] got = '0;
      int exp_stall;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      rd_seen = 0; wr_seen = 0; order_err = 0;
      cur_blk = {a[31:4], 4'h0};
      for (int k = 0; k < 200 && !done; k++) begin
         #1;
         if (!cpu_stall) begin
            done = 1;
            got = cpu_rdata;
         end else begin
            stalls++;
            @(negedge clk);
         end
      end
      chk("R10", "access completes", 32'(done), 32'd1);
      @(posedge clk);
      #1;
      if (!we) chk("R4", $sformatf("read data @%h", a), got, model_rd(a));
      chk(miss ? "R5" : "R3", $sformatf("refill reads @%h", a), 32'(rd_seen), miss ? 32'd4 : 32'd0);
      chk("R5", "refill order", 32'(order_err), 32'd0);
      chk("R6", $sformatf("memory writes @%h", a), 32'(wr_seen), we ? 32'd1 : 32'd0);
      if (we) begin
         chk("R6", "write address", last_waddr, {a[31:2], 2'b00});
         chk("R6", "write data", last_wdata, wd);
      end
      if (!wait_mode) begin
         exp_stall = we ? (miss ? 6 : 1) : (miss ? 5 : 0);
         chk("R10", $sformatf("stall cycles @%h", a), 32'(stalls), 32'(exp_stall));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Vector fields: [65] store, [64:33] address, [32:1] store data, [0] miss expected.
   localparam int NV = 18;
   localparam logic [65:0] VEC [NV] = '{
      {1'b0, 32'h0000_0014, 32'h0,          1'b1}, // R9 cold line 1
      {1'b0, 32'h0000_001C, 32'h0,          1'b0}, // R9 R4 word 3 hit
      {1'b0, 32'h0000_0034, 32'h0,          1'b1}, // R9 line 3
      {1'b0, 32'h0002_0014, 32'h0,          1'b1}, // R9 R3 tag 2 mismatch
      {1'b0, 32'h0002_0018, 32'h0,          1'b0}, // R3 hit on new tag
      {1'b0, 32'h0000_0014, 32'h0,          1'b1}, // R9 tag 0 evicted
      {1'b0, 32'h0000_0013, 32'h0,          1'b0}, // R2 byte offset ignored
      {1'b1, 32'h0000_001C, 32'hDEAD_BEEF,  1'b0}, // R6 R7 store hit
      {1'b0, 32'h0000_001C, 32'h0,          1'b0}, // R7 read back
      {1'b1, 32'h0001_2344, 32'h1234_5678,  1'b1}, // R8 store miss
      {1'b0, 32'h0001_2340, 32'h0,          1'b0}, // R8 neighbour from memory
      {1'b0, 32'h0001_2344, 32'h0,          1'b0}, // R8 merged word
      {1'b1, 32'h0000_003C, 32'h0BAD_F00D,  1'b0}, // R6 store hit line 3
      {1'b0, 32'h0003_0038, 32'h0,          1'b1}, // R3 evicts line 3
      {1'b0, 32'h0000_003C, 32'h0,          1'b1}, // R6 memory kept the store
      {1'b0, 32'hFFFF_FFF0, 32'h0,          1'b1}, // R2 top index and tag
      {1'b0, 32'hFFFF_FFFF, 32'h0,          1'b0}, // R4 word 3, byte 3
      {1'b0, 32'h0000_8014, 32'h0,          1'b1}  // R2 index bit 15
   };

   task automatic run_table();
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      #1;
      // R1 R11: reset state with no request
      chk("R1", "stall after reset", 32'(cpu_stall), 32'd0);
      chk("R11", "mem_req after reset", 32'(mem_req), 32'd0);

      run_table();

      // R11: idle cycles produce no memory transfers
      idle_xfers = 0;
      repeat (10) @(negedge clk);
      chk("R11", "idle transfers", 32'(idle_xfers), 32'd0);
      chk("R11", "idle stall", 32'(cpu_stall), 32'd0);

      // R1: reset invalidates lines that were valid
      do_reset();
      access(1'b0, 32'h0000_001C, 32'h0, 1'b1);
      access(1'b0, 32'h0000_0018, 32'h0, 1'b0);

      // Second pass against a slow memory (R10 hold rule)
      do_reset();
      wait_mode = 1'b1;
      run_table();
      chk("R10", "hold violations", 32'(hold_err), 32'd0);

      finish_run();
   end
endmodule